// File: doc/BRIEF.md
# Four-State Invalidation Snoop Controller

This block keeps the coherence state of every line of a small snooping write-back cache. It uses a four-state invalidation protocol: Invalid, Shared, Exclusive (the only cached copy, and still clean) and Modified (dirty). It has two sides. On the processor side it accepts read, write and eviction requests and turns them into bus requests where the protocol needs one. On the snoop side it answers transactions that other caches place on the bus, raising the wired-OR shared response and a flush indication and invalidating or downgrading its own copy.

The state of each line is held in a table of `LINES` two-bit entries. A processor request names a line. When the stored state already allows the access, the request completes in the cycle it is presented. Otherwise the block holds a bus request until the bus grants it. At that grant the shared line sampled on a bus read decides between Exclusive and Shared. Because of the Exclusive state, a private read followed by a write costs only one bus transaction.

Back-pressure: the processor must hold `cpu_valid`, `cpu_op` and `cpu_line` stable until `cpu_ready` is high in the same cycle. The block holds `bus_req_valid`, `bus_req_cmd` and `bus_req_line` stable until `bus_gnt`. A request completes in the grant cycle. Snoop inputs are plain, one transaction per cycle in which `snoop_valid` is high, and they cannot be stalled.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, using the encoding I=00, S=01, E=10, M=11. With no activity, `bus_req_valid`, `snoop_shared` and `snoop_flush` are low.
- R2: A read (`cpu_op`=00) to an Invalid line raises a bus read (`bus_req_cmd`=00). At the grant it completes with state S if `bus_shared_in` is high and E if it is low.
- R3: A write (`cpu_op`=01) to an Exclusive line completes in the cycle it is presented, with state M and no bus request.
- R4: A write to an Invalid or Shared line raises a bus read-exclusive (`bus_req_cmd`=01) and completes with state M at the grant.
- R5: Reads to S, E or M lines and writes to M lines complete in the cycle they are presented, leave the state unchanged and raise no bus request.
- R6: A snooped bus read (`snoop_cmd`=0) moves M to S with `snoop_flush` high, moves E to S and leaves S as S. `snoop_shared` is high exactly when the line is not Invalid.
- R7: A snooped bus read-exclusive (`snoop_cmd`=1) leaves the line Invalid. It flushes only if the line was M and never raises `snoop_shared`.
- R8: Only a Modified line supplies flush data. Snoops that hit E or S lines never raise `snoop_flush`.
- R9: An eviction (`cpu_op`=10) of an M line raises a write-back (`bus_req_cmd`=10) and completes with state I at the grant. Evicting an I, S or E line completes at once with state I and no bus request.
- R10: A bus request stays asserted with its command and line unchanged until `bus_gnt`. `cpu_ready` rises only in the completing cycle. `cpu_op`=11 completes at once and reports the line's current state without changing it.
- R11: A snoop to the same line as an idle processor request stalls that request for the cycle and is applied first. If a grant and a snoop write the same line in one cycle, the grant's state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_op | input | 2 | 00 read, 01 write, 10 evict, 11 state query |
| cpu_line | input | IW | Line index of the request |
| cpu_state | output | 2 | Line state after the completing request |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 00 bus read, 01 read-exclusive, 10 write-back |
| bus_req_line | output | IW | Line of the bus transaction |
| bus_gnt | input | 1 | Bus transaction performed this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled at grant |
| snoop_valid | input | 1 | Snooped transaction present |
| snoop_cmd | input | 1 | 0 bus read, 1 bus read-exclusive |
| snoop_line | input | IW | Line index of the snooped transaction |
| snoop_shared | output | 1 | This cache holds the snooped line (bus read) |
| snoop_flush | output | 1 | This cache supplies dirty data |
| snoop_state | output | 2 | Line state after the snoop |

## Verification
A wrong stored state shows at the ports on the next access to that line. A missing or extra bus request is visible in the same cycle as the processor request. A wrong shared or flush answer is visible in the same cycle as the snoop. A wrong fill state is reported by `cpu_state` at the grant. The bench therefore compares every port against an independent model on every clock. It reaches every line state from both sides, and it drives random snoops that collide with idle and pending processor requests, so a corrupted entry is caught within a few cycles of the access that exposes it.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} line_st_t;
  typedef enum logic [1:0] {OP_RD = 2'b00, OP_WR = 2'b01, OP_EV = 2'b10, OP_NOP = 2'b11} cpu_op_t;
  typedef enum logic [1:0] {BC_RD = 2'b00, BC_RDX = 2'b01, BC_WB = 2'b10, BC_NONE = 2'b11} bus_cmd_t;

  function automatic bus_cmd_t bus_need(cpu_op_t op, line_st_t st);
    case (op)
      OP_RD:   return (st == ST_I) ? BC_RD : BC_NONE;
      OP_WR:   return (st == ST_I || st == ST_S) ? BC_RDX : BC_NONE;
      OP_EV:   return (st == ST_M) ? BC_WB : BC_NONE;
      default: return BC_NONE;
    endcase
  endfunction

  function automatic line_st_t local_next(cpu_op_t op, line_st_t st);
    case (op)
      OP_WR:   return ST_M;
      OP_EV:   return ST_I;
      default: return st;
    endcase
  endfunction

  function automatic line_st_t grant_next(cpu_op_t op, logic shared);
    case (op)
      OP_RD:   return shared ? ST_S : ST_E;
      OP_WR:   return ST_M;
      default: return ST_I;
    endcase
  endfunction

  function automatic line_st_t snoop_next(logic rdx, line_st_t st);
    if (rdx || st == ST_I) return ST_I;
    return ST_S;
  endfunction
endpackage

// File: rtl/mesi_state_table.sv
module mesi_state_table #(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        cpu_idx,
  output mesi_pkg::line_st_t   cpu_st,
  input  logic [IW-1:0]        snp_idx,
  output mesi_pkg::line_st_t   snp_st,
  input  logic                 we_a,
  input  logic [IW-1:0]        idx_a,
  input  mesi_pkg::line_st_t   st_a,
  input  logic                 we_b,
  input  logic [IW-1:0]        idx_b,
  input  mesi_pkg::line_st_t   st_b
);
  import mesi_pkg::*;

  line_st_t ent [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[g] <= ST_I;
      else if (we_a && idx_a == IW'(g))
        ent[g] <= st_a;
      else if (we_b && idx_b == IW'(g))
        ent[g] <= st_b;
    end
  end

  assign cpu_st = ent[cpu_idx];
  assign snp_st = ent[snp_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp (
  input  logic               snoop_valid,
  input  logic               snoop_cmd,
  input  mesi_pkg::line_st_t cur_st,
  output logic               shared_o,
  output logic               flush_o,
  output mesi_pkg::line_st_t next_st,
  output logic               we
);
  import mesi_pkg::*;

  always_comb begin
    next_st  = snoop_next(snoop_cmd, cur_st);
    shared_o = snoop_valid && !snoop_cmd && (cur_st != ST_I);
    flush_o  = snoop_valid && (cur_st == ST_M);
    we       = snoop_valid && (cur_st != ST_I);
  end
endmodule

// File: rtl/mesi_cpu_seq.sv
module mesi_cpu_seq #(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  input  logic [1:0]         cpu_op,
  input  logic [IW-1:0]      cpu_line,
  input  mesi_pkg::line_st_t cur_st,
  input  logic               collide,
  input  logic               bus_gnt,
  input  logic               bus_shared_in,
  output logic               cpu_ready,
  output mesi_pkg::line_st_t cpu_state,
  output logic               bus_req_valid,
  output logic [1:0]         bus_req_cmd,
  output logic [IW-1:0]      bus_req_line,
  output logic               wr_en,
  output logic [IW-1:0]      wr_idx,
  output mesi_pkg::line_st_t wr_st
);
  import mesi_pkg::*;

  typedef enum logic {SQ_IDLE, SQ_BUS} seq_t;

  seq_t     seq;
  cpu_op_t  pend_op;
  bus_cmd_t pend_cmd;
  logic [IW-1:0] pend_line;

  cpu_op_t  op;
  bus_cmd_t need;
  logic     local_ok, grant_ok, launch;

  always_comb begin
    op        = cpu_op_t'(cpu_op);
    need      = bus_need(op, cur_st);
    local_ok  = (seq == SQ_IDLE) && cpu_valid && (need == BC_NONE) && !collide;
    launch    = (seq == SQ_IDLE) && cpu_valid && (need != BC_NONE) && !collide;
    grant_ok  = (seq == SQ_BUS) && bus_gnt;
    cpu_ready = local_ok || grant_ok;
    cpu_state = grant_ok ? grant_next(pend_op, bus_shared_in) : local_next(op, cur_st);
    wr_en     = grant_ok || (local_ok && op != OP_NOP);
    wr_idx    = grant_ok ? pend_line : cpu_line;
    wr_st     = cpu_state;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq       <= SQ_IDLE;
      pend_op   <= OP_NOP;
      pend_cmd  <= BC_NONE;
      pend_line <= '0;
    end else if (launch) begin
      seq       <= SQ_BUS;
      pend_op   <= op;
      pend_cmd  <= need;
      pend_line <= cpu_line;
    end else if (grant_ok) begin
      seq       <= SQ_IDLE;
    end
  end

  assign bus_req_valid = (seq == SQ_BUS);
  assign bus_req_cmd   = pend_cmd;
  assign bus_req_line  = pend_line;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic [1:0]    cpu_op,
  input  logic [IW-1:0] cpu_line,
  output logic [1:0]    cpu_state,
  output logic          bus_req_valid,
  output logic [1:0]    bus_req_cmd,
  output logic [IW-1:0] bus_req_line,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  input  logic          snoop_valid,
  input  logic          snoop_cmd,
  input  logic [IW-1:0] snoop_line,
  output logic          snoop_shared,
  output logic          snoop_flush,
  output logic [1:0]    snoop_state
);
  import mesi_pkg::*;

  line_st_t cpu_cur, snp_cur, snp_nxt, wr_st, cst;
  logic     wr_en, snp_we, collide;
  logic [IW-1:0] wr_idx;

  assign collide = snoop_valid && (snoop_line == cpu_line);

  mesi_state_table #(.LINES(LINES)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(cpu_line), .cpu_st(cpu_cur),
    .snp_idx(snoop_line), .snp_st(snp_cur),
    .we_a(wr_en), .idx_a(wr_idx), .st_a(wr_st),
    .we_b(snp_we), .idx_b(snoop_line), .st_b(snp_nxt)
  );

  mesi_snoop_resp u_snp (
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .cur_st(snp_cur),
    .shared_o(snoop_shared), .flush_o(snoop_flush), .next_st(snp_nxt), .we(snp_we)
  );

  mesi_cpu_seq #(.LINES(LINES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_line(cpu_line),
    .cur_st(cpu_cur), .collide(collide),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .cpu_ready(cpu_ready), .cpu_state(cst),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_line(bus_req_line),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st)
  );

  assign cpu_state   = cst;
  assign snoop_state = snp_nxt;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic          cpu_ready,
  input logic [1:0]    cpu_state,
  input logic          bus_req_valid,
  input logic [1:0]    bus_req_cmd,
  input logic [IW-1:0] bus_req_line,
  input logic          bus_gnt,
  input logic          bus_shared_in,
  input logic          snoop_valid,
  input logic          snoop_cmd,
  input logic          snoop_shared,
  input logic          snoop_flush,
  input logic [1:0]    snoop_state
);
  a_r2_fill_by_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && bus_req_valid && bus_req_cmd == 2'b00)
      |-> cpu_state == (bus_shared_in ? 2'b01 : 2'b10));

  a_r4_rdx_gives_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && bus_req_valid && bus_req_cmd == 2'b01) |-> cpu_state == 2'b11);

  a_r6_flush_downgrades: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && !snoop_cmd && snoop_flush) |-> (snoop_state == 2'b01 && snoop_shared));

  a_r7_rdx_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_cmd) |-> (snoop_state == 2'b00 && !snoop_shared));

  a_r9_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && bus_req_valid && bus_req_cmd == 2'b10) |-> cpu_state == 2'b00);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_gnt)
      |=> (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_line)));

  a_r10_req_from_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) |-> $past(cpu_valid));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_state(cpu_state), .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
  .bus_req_line(bus_req_line), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
  .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_shared(snoop_shared),
  .snoop_flush(snoop_flush), .snoop_state(snoop_state)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
  localparam int LINES = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_ready;
  logic [1:0] cpu_op = 0, cpu_state;
  logic [IW-1:0] cpu_line = 0;
  logic bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [IW-1:0] bus_req_line;
  logic bus_gnt = 0, bus_shared_in = 0;
  logic snoop_valid = 0, snoop_cmd = 0;
  logic [IW-1:0] snoop_line = 0;
  logic snoop_shared, snoop_flush;
  logic [1:0] snoop_state;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0, rand_snp = 0;
  string cur_req = "R1";

  // reference model: 0=I 1=S 2=E 3=M
  int mst [LINES];
  bit m_pend = 0;
  int m_pop, m_pline, m_pcmd;
  bit e_hs, e_need, e_coll;
  int e_cs, e_ss;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int cur, sc;
    bit rdy, sh, fl;
    cur = mst[cpu_line];
    e_need = (cpu_op == 0 && cur == 0) || (cpu_op == 1 && cur <= 1) || (cpu_op == 2 && cur == 3);
    e_coll = snoop_valid && (snoop_line == cpu_line);
    rdy = m_pend ? bus_gnt : (cpu_valid && !e_need && !e_coll);
    e_hs = cpu_valid && rdy;
    if (m_pend) e_cs = (m_pop == 0) ? (bus_shared_in ? 1 : 2) : (m_pop == 1) ? 3 : 0;
    else e_cs = (cpu_op == 1) ? 3 : (cpu_op == 2) ? 0 : cur;
    sc = mst[snoop_line];
    sh = snoop_valid && !snoop_cmd && sc != 0;
    fl = snoop_valid && sc == 3;
    e_ss = (snoop_cmd || sc == 0) ? 0 : 1;
    chk(cpu_ready == rdy, "cpu_ready", cpu_ready, rdy);
    if (e_hs) chk(cpu_state == e_cs, "cpu_state", cpu_state, e_cs);
    chk(bus_req_valid == m_pend, "bus_req_valid", bus_req_valid, m_pend);
    if (m_pend) begin
      chk(bus_req_cmd == m_pcmd, "bus_req_cmd", bus_req_cmd, m_pcmd);
      chk(bus_req_line == m_pline, "bus_req_line", bus_req_line, m_pline);
    end
    chk(snoop_shared == sh, "snoop_shared", snoop_shared, sh);
    chk(snoop_flush == fl, "snoop_flush", snoop_flush, fl);
    if (snoop_valid) chk(snoop_state == e_ss, "snoop_state", snoop_state, e_ss);
  endtask

  task automatic update();
    if (snoop_valid) mst[snoop_line] = e_ss;
    if (e_hs) mst[m_pend ? m_pline : int'(cpu_line)] = e_cs;
    if (!m_pend && cpu_valid && e_need && !e_coll) begin
      m_pend = 1; m_pop = cpu_op; m_pline = cpu_line; m_pcmd = cpu_op;
    end else if (m_pend && bus_gnt) m_pend = 0;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic cpu_do(int op, int line, int dly, bit shin, string req);
    int w = 0;
    bit seen = 0;
    cur_req = req;
    cpu_valid = 1; cpu_op = op[1:0]; cpu_line = line[IW-1:0];
    for (int i = 0; i < 60 && !seen; i++) begin
      bus_gnt = m_pend && (w >= dly);
      bus_shared_in = shin;
      if (rand_snp) begin
        snoop_valid = ($urandom_range(0, 2) == 0);
        snoop_cmd = $urandom_range(0, 1) == 1;
        snoop_line = IW'($urandom_range(0, LINES - 1));
      end
      tick();
      seen = e_hs;
      if (m_pend) w++;
    end
    cpu_valid = 0; bus_gnt = 0; bus_shared_in = 0; snoop_valid = 0;
  endtask

  task automatic snoop_do(bit cmd, int line, string req);
    cur_req = req;
    snoop_valid = 1; snoop_cmd = cmd; snoop_line = line[IW-1:0];
    tick();
    snoop_valid = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) mst[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, all lines report I via query
    cur_req = "R1"; tick();
    for (int i = 0; i < LINES; i++) cpu_do(3, i, 0, 0, "R1");
    // R2: read miss, not shared -> E; R5 hit
    cpu_do(0, 0, 2, 0, "R2");
    cpu_do(0, 0, 0, 0, "R5");
    // R3: write in E goes M locally
    cpu_do(1, 0, 0, 0, "R3");
    cpu_do(1, 0, 0, 0, "R5");
    // R6: snoop read of M flushes, to S
    snoop_do(0, 0, "R6");
    // R4: write in S -> read-exclusive, M; R10 long grant wait
    cpu_do(1, 0, 4, 0, "R10");
    // R7: snoop rdx of M flushes, to I
    snoop_do(1, 0, "R7");
    cpu_do(3, 0, 0, 0, "R7");
    // R2 shared fill, R6 shared response, R8 no flush from S
    cpu_do(0, 1, 1, 1, "R2");
    snoop_do(0, 1, "R8");
    snoop_do(1, 1, "R7");
    // R8: E downgraded without flush
    cpu_do(0, 2, 0, 0, "R2");
    snoop_do(0, 2, "R8");
    // R4: write miss from I
    cpu_do(1, 3, 1, 0, "R4");
    // R9: dirty eviction writes back; clean eviction silent
    cpu_do(2, 3, 2, 0, "R9");
    cpu_do(0, 4, 0, 0, "R9");
    cpu_do(2, 4, 0, 0, "R9");
    cpu_do(3, 4, 0, 0, "R9");
    // R11: collision with idle request
    cpu_do(0, 5, 0, 0, "R11");
    cur_req = "R11";
    cpu_valid = 1; cpu_op = 2'b01; cpu_line = 3'd5;
    snoop_valid = 1; snoop_cmd = 0; snoop_line = 3'd5;
    tick();
    snoop_valid = 0;
    cpu_do(1, 5, 1, 0, "R11");
    // random phase with snoops over all lines
    rand_snp = 1;
    for (int n = 0; n < 400; n++)
      cpu_do($urandom_range(0, 3), $urandom_range(0, LINES - 1),
             $urandom_range(0, 3), $urandom_range(0, 1) == 1, "R11");
    rand_snp = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule